// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory. The upper bits come straight from an externally supplied address. The two least significant bits walk through a four-beat burst. Either of two address-strobe inputs captures the external address. On every later cycle in which the advance input is high, the low bits step to the next beat.

The beat order is chosen by a mode input. Tying it low gives interleaved (XOR) order, which is the intended default. Tying it high gives linear order, modulo four. Bursting is optional. A strobe may be applied on every cycle, and each one loads a fresh address with no dead cycle between loads.

All inputs are sampled on the rising clock edge. The address output is registered, so it reflects a load or a step on the cycle after the edge that sampled it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr_out` is zero.
- R2: When `strobe_a` or `strobe_b` is high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge from the following cycle on.
- R3: With `order_sel` = 1 (linear), the low two bits of beat n equal (start offset + n) mod 4. The start offset is the low two bits of the loaded address.
- R4: With `order_sel` = 0 (interleaved, the default tie-off), the low two bits of beat n equal start offset XOR n.
- R5: An advance never changes the bits of `addr_out` above the low two, even when the low bits wrap from 3 to 0.
- R6: After four advances the low bits return to the start offset, and further advances repeat the same cycle. In both orders every advance inverts bit 0.
- R7: When a strobe and `advance` are high at the same edge, the strobe wins: the external address is loaded and the beat count restarts at zero.
- R8: With both strobes and `advance` low, `addr_out` holds its value regardless of `addr_in`.
- R9: Strobes on consecutive cycles each load their own address, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_a | input | 1 | First burst-start strobe; loads `addr_in` |
| strobe_b | input | 1 | Second burst-start strobe; loads `addr_in` |
| advance | input | 1 | Steps the burst to the next beat |
| order_sel | input | 1 | Beat order: 0 interleaved, 1 linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current word address |

## Verification
Two functions can fall in the same edge: a strobe and an advance. The same applies to two strobes on back-to-back cycles.

The bench provokes the first case by raising `strobe_a`, or both strobes, together with `advance` in the middle of a running burst. It then expects `addr_out` to show exactly the new external address. On the next advance it expects beat 1 of the new burst, counted from the new start offset and not from the old beat count.

Back-to-back strobes are judged by expecting each loaded address, unchanged, on the cycle right after its own strobe.

// File: rtl/bas_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes nothing beyond a two-valued order selection input.
package bas_pkg;

    // Beat ordering selected by the mode input; low is the default tie-off.
    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bas_start_reg.sv
// Module: bas_start_reg
// Holds the fixed upper address bits and the burst start offset captured
// on a load. Assumes load is the OR of all strobes, sampled on the rising edge.
module bas_start_reg #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-CNT_W-1:0] upper_q,
    output logic [CNT_W-1:0]  start_q
);
    localparam int UP_W = ADDR_W - CNT_W;

    // Capture upper bits and start offset on a load; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:CNT_W];
            start_q <= addr_in[CNT_W-1:0];
        end
    end

    // UP_W documents the upper field width used for the slice above.
    initial begin
        if (UP_W < 1) $error("bas_start_reg: ADDR_W must exceed CNT_W");
    end
endmodule

// File: rtl/bas_beat_ctr.sv
// Module: bas_beat_ctr
// Counts beats within a burst, modulo 2**CNT_W. A load clears the count and
// takes priority over a step. Assumes step is already masked by load.
module bas_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] beat_q,
    output logic [CNT_W-1:0] beat_nxt
);
    // Next beat number, wrapping naturally at the counter width.
    always_comb begin
        beat_nxt = beat_q + CNT_W'(1);
    end

    // Clear on load, advance on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_nxt;
        end
    end
endmodule

// File: rtl/bas_order_map.sv
// Module: bas_order_map
// Maps a start offset and a beat number to the low address bits in either
// linear (sum) or interleaved (XOR) order. Purely combinational.
module bas_order_map
    import bas_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             [CNT_W-1:0] start,
    input  logic             [CNT_W-1:0] beat,
    input  burst_order_e                 order,
    output logic             [CNT_W-1:0] offset
);
    logic [CNT_W-1:0] lin_off;
    logic [CNT_W-1:0] xor_off;

    // Interleaved order: one XOR per bit, built bit by bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_off[b] = start[b] ^ beat[b];
    end

    // Linear order: add and drop the carry out of the counter width.
    always_comb begin
        lin_off = start + beat;
    end

    // Select the order requested by the mode input.
    always_comb begin
        offset = (order == ORD_LINEAR) ? lin_off : xor_off;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Word address generator for a synchronous burst memory. Either strobe loads
// addr_in. An advance steps the low CNT_W bits through the burst in the
// selected order. The output is registered. Assumes order_sel is static
// within a burst.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic             load;
    logic             step;
    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] beat_q;
    logic [CNT_W-1:0] beat_nxt;
    logic [CNT_W-1:0] next_off;
    logic [CNT_W-1:0] low_q;
    burst_order_e     order;

    // Decode burst control: any strobe loads, and an advance only steps without one.
    always_comb begin
        load  = strobe_a | strobe_b;
        step  = advance & ~load;
        order = burst_order_e'(order_sel);
    end

    bas_start_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .upper_q (upper_q),
        .start_q (start_q)
    );

    bas_beat_ctr #(.CNT_W(CNT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .beat_q   (beat_q),
        .beat_nxt (beat_nxt)
    );

    bas_order_map #(.CNT_W(CNT_W)) u_map (
        .start  (start_q),
        .beat   (beat_nxt),
        .order  (order),
        .offset (next_off)
    );

    // Register the low address bits: the raw offset on load, the mapped beat on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (load) begin
            low_q <= addr_in[CNT_W-1:0];
        end else if (step) begin
            low_q <= next_off;
        end
    end

    // Assemble the output word from the fixed upper part and the beat offset.
    always_comb begin
        addr_out = {upper_q, low_q};
    end
endmodule

// File: rtl/bas_checker.sv
// Module: bas_checker
// Concurrent properties for burst_addr_seq, observed at its ports and
// attached with the bind statement at the end of this file.
module bas_checker #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    // R1: reset drives the address to zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

    // R2: a strobe loads the sampled external address.
    p_strobe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_a || strobe_b) |=> addr_out == $past(addr_in));

    // R7: a strobe beats a simultaneous advance.
    p_strobe_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_a || strobe_b) && advance) |=> addr_out == $past(addr_in));

    // R5: an advance keeps the upper bits.
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_a && !strobe_b && advance) |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    // R6: every advance inverts bit 0, in either order.
    p_bit0_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_a && !strobe_b && advance) |=> addr_out[0] != $past(addr_out[0]));

    // R8: no strobe and no advance hold the address.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_a && !strobe_b && !advance) |=> $stable(addr_out));
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_a  (strobe_a),
    .strobe_b  (strobe_b),
    .advance   (advance),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
// Bench for burst_addr_seq: a table walk followed by directed reset and
// interleaved-from-zero checks. Inputs change on the falling edge; the output
// is sampled on the next falling edge, after the registered update.
module burst_addr_seq_tb;
    localparam int ADDR_W = 18;
    localparam int NVEC   = 21;

    typedef struct packed {
        logic              sa;
        logic              sb;
        logic              adv;
        logic              lin;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    // Fields: strobe_a, strobe_b, advance, order_sel, addr_in, expected addr_out, requirement.
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h12345, 18'h12345, 4'd2}, // R2 load via strobe_a
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h12344, 4'd4}, // R4 beat 1: 01^01
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12347, 4'd4}, // R4 beat 2: 01^10
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12346, 4'd4}, // R4 beat 3: 01^11
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12345, 4'd6}, // R6 wrap to start
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12344, 4'd6}, // R6 cycle repeats
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h2AAAA, 18'h12344, 4'd8}, // R8 hold, addr_in ignored
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h0ABCE, 18'h0ABCE, 4'd2}, // R2 load via strobe_b
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h0ABCF, 4'd3}, // R3 10+1
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h0ABCC, 4'd5}, // R5 low wraps, upper fixed
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h0ABCD, 4'd3}, // R3 10+3
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h0ABCE, 4'd6}, // R6 back to start
        '{1'b1, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF, 4'd7}, // R7 strobe beats advance
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h3FFFC, 4'd5}, // R5 no carry into upper
        '{1'b1, 1'b0, 1'b0, 1'b1, 18'h00001, 18'h00001, 4'd9}, // R9 back-to-back load 1
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h20002, 18'h20002, 4'd9}, // R9 back-to-back load 2
        '{1'b1, 1'b1, 1'b1, 1'b0, 18'h15556, 18'h15556, 4'd7}, // R7 both strobes + advance
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h15557, 4'd4}, // R4 10^01
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h15554, 4'd4}, // R4 10^10
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h15555, 4'd4}, // R4 10^11
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h15556, 4'd6}  // R6 wrap
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_a = 1'b0;
    logic              strobe_b = 1'b0;
    logic              advance = 1'b0;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_a  (strobe_a),
        .strobe_b  (strobe_b),
        .advance   (advance),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    task automatic check(input int req, input logic [ADDR_W-1:0] exp);
        n_run++;
        if (addr_out !== exp) begin
            n_fail++;
            $display("FAIL R%0d: addr_out=%05h expected=%05h", req, addr_out, exp);
        end
    endtask

    task automatic drive(input logic sa, input logic sb, input logic adv,
                         input logic lin, input logic [ADDR_W-1:0] a);
        strobe_a  = sa;
        strobe_b  = sb;
        advance   = adv;
        order_sel = lin;
        addr_in   = a;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: in reset, with a strobe applied, the output stays zero.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 18'h2FFFF);
        repeat (3) @(negedge clk);
        check(1, '0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h2FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, '0);

        // Table walk: drive at a falling edge, check at the next one.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].sa, VEC[i].sb, VEC[i].adv, VEC[i].lin, VEC[i].a);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].exp);
        end

        // R1: reset in the middle of a burst clears the output.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFFE);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 18'h0);
        @(negedge clk);
        check(3, 18'h3FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, '0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'h0);
        @(negedge clk);
        check(1, '0);

        // R4: interleaved from offset 0 after a load of 0x00010 gives 1, 2, 3.
        drive(1'b0, 1'b1, 1'b0, 1'b0, 18'h00010);
        @(negedge clk);
        check(2, 18'h00010);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 18'h0);
        @(negedge clk);
        check(4, 18'h00011);
        @(negedge clk);
        check(4, 18'h00012);
        @(negedge clk);
        check(4, 18'h00013);

        // R3: linear from offset 3 gives 0, 1 next.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h10003);
        @(negedge clk);
        check(2, 18'h10003);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 18'h0);
        @(negedge clk);
        check(3, 18'h10000);
        @(negedge clk);
        check(3, 18'h10001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule